// File: doc/BRIEF.md
# Eight-Channel DAC Register Bank with Per-Channel Load Mask

This block is the digital control core of an eight-channel serial DAC. A host shifts 32-bit command frames in over a three-wire serial link: an active-low frame select, a serial clock, and a data line. The block decodes a command, a channel address and a data word from each frame. It holds a staging (input) register and an output (DAC) register for every channel. The outputs are the concatenated DAC register values.

An output register can change in four ways. A command can update it. A software command can update all channels at once. The active-low load pin can go low, either as an edge or held low when a frame completes. Finally, a channel whose bit is set in the 8-bit load mask updates itself as soon as its staging register is written, whatever the load pin is doing. All serial and pin inputs are sampled in the system clock domain through synchronizer chains. Clock and pin falling edges are found by edge detection.

Top module: `octal_dac_core`

## Requirements
- R1: After reset every staging register, every DAC register and every mask bit is 0, so `dac_out` is 0.
- R2: A frame is 32 bits sent MSB first while `sync_n` is low, one bit per falling `sclk` edge. Bits 27..24 hold the command, bits 23..20 hold the address, and bits 19..6 hold the 14-bit data. The frame takes effect on the 32rd falling edge. Any further edges before `sync_n` rises are ignored.
- R3: If `sync_n` rises before 32 bits have arrived, the frame is dropped and changes nothing.
- R4: Command 0000 writes staging register n only. With `ldac_n` high and mask bit n at 0, `dac_out` does not change.
- R5: Command 0001 copies staging register n into DAC register n.
- R6: Command 0010 writes staging register n and then DAC register n with the frame data.
- R7: Command 0011 writes staging register n and then copies every staging register into its DAC register.
- R8: Command 0110 loads the mask from frame bits 7..0, where bit i belongs to channel i. The address and bits 19..8 of that frame are ignored.
- R9: When mask bit i is 1, any write to staging register i also updates DAC register i, whatever the state of `ldac_n`.
- R10: A falling edge on `ldac_n` copies the staging register into the DAC register for every channel whose mask bit is 0.
- R11: If `ldac_n` is low when a frame completes, every channel whose mask bit is 0 copies its staging register, including any data just written, into its DAC register.
- R12: Address 1111 selects all channels. Addresses 1000..1110 select none. Commands other than 0000, 0001, 0010, 0011 and 0110 change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sclk | input | 1 | Serial clock, data taken on its falling edge |
| sync_n | input | 1 | Active-low frame select |
| din | input | 1 | Serial data, MSB first |
| ldac_n | input | 1 | Active-low DAC load pin |
| dac_out | output | NCH*DW | DAC register values, channel 0 in the low bits |

## Verification
The bench builds the block with its default values: eight channels, 14-bit data and two-stage synchronizers. With eight channels the address space splits into valid channels, dead addresses 1000..1110, and the broadcast address. This lets broadcast writes, ignored addresses and every mask bit be exercised in one build. The bench holds the serial clock for four system cycles per phase. As a result, every frame edge passes through the synchronizers cleanly. Random mask values, load-pin toggles and the load pin held low at frame completion are mixed with short and overlong frames.

// File: rtl/octal_dac_core.sv
module octal_dac_core #(
  parameter int NCH = 8,
  parameter int DW = 14,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sclk,
  input  logic              sync_n,
  input  logic              din,
  input  logic              ldac_n,
  output logic [NCH*DW-1:0] dac_out
);
  localparam int FRAME = 32;
  localparam int CW = $clog2(FRAME + 1);

  logic [SYNC_STAGES-1:0] sclk_p, sync_p, din_p, ldac_p;
  logic sclk_q, ldac_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_p <= '1;
      sync_p <= '1;
      din_p  <= '0;
      ldac_p <= '1;
      sclk_q <= 1'b1;
      ldac_q <= 1'b1;
    end else begin
      sclk_p <= {sclk_p[SYNC_STAGES-2:0], sclk};
      sync_p <= {sync_p[SYNC_STAGES-2:0], sync_n};
      din_p  <= {din_p[SYNC_STAGES-2:0], din};
      ldac_p <= {ldac_p[SYNC_STAGES-2:0], ldac_n};
      sclk_q <= sclk_p[SYNC_STAGES-1];
      ldac_q <= ldac_p[SYNC_STAGES-1];
    end
  end

  wire sclk_s = sclk_p[SYNC_STAGES-1];
  wire sync_s = sync_p[SYNC_STAGES-1];
  wire din_s  = din_p[SYNC_STAGES-1];
  wire ldac_s = ldac_p[SYNC_STAGES-1];

  wire sclk_fall = sclk_q & ~sclk_s;
  wire ldac_fall = ldac_q & ~ldac_s;

  logic [CW-1:0]    cnt;
  logic [FRAME-2:0] shreg;

  wire capture = sclk_fall & ~sync_s & (cnt != CW'(FRAME));
  wire exec    = capture & (cnt == CW'(FRAME - 1));
  wire [FRAME-1:0] frame = {shreg, din_s};
  wire [3:0] cmd  = frame[27:24];
  wire [3:0] addr = frame[23:20];
  wire [DW-1:0] data = frame[19 -: DW];
  wire wr_cmd = (cmd == 4'h0) | (cmd == 4'h2) | (cmd == 4'h3);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt   <= '0;
      shreg <= '0;
    end else if (sync_s) begin
      cnt <= '0;
    end else if (capture) begin
      cnt   <= cnt + 1'b1;
      shreg <= frame[FRAME-2:0];
    end
  end

  logic [DW-1:0] inp [NCH];
  logic [DW-1:0] dac [NCH];
  logic [DW-1:0] inp_nx [NCH];
  logic [NCH-1:0] mask, sel, upd;

  always_comb begin
    for (int i = 0; i < NCH; i++) begin
      sel[i] = (addr == 4'hF) | (addr == 4'(i));
      inp_nx[i] = (exec && wr_cmd && sel[i]) ? data : inp[i];
      upd[i] = (ldac_fall & ~mask[i])
             | (exec & ((~ldac_s & ~mask[i])
                      | (cmd == 4'h3)
                      | (sel[i] & ((cmd == 4'h1) | (cmd == 4'h2)))
                      | (sel[i] & mask[i] & (cmd == 4'h0))));
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask <= '0;
      for (int i = 0; i < NCH; i++) begin
        inp[i] <= '0;
        dac[i] <= '0;
      end
    end else begin
      if (exec && cmd == 4'h6) mask <= frame[NCH-1:0];
      for (int i = 0; i < NCH; i++) begin
        inp[i] <= inp_nx[i];
        if (upd[i]) dac[i] <= inp_nx[i];
      end
    end
  end

  for (genvar g = 0; g < NCH; g++) begin : g_out
    assign dac_out[g*DW +: DW] = dac[g];

    assert_masked_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
      exec && wr_cmd && sel[g] && mask[g] |=> dac[g] == $past(data));

    assert_pin_load_R10: assert property (@(posedge clk) disable iff (!rst_n)
      ldac_fall && !mask[g] |=> dac[g] == inp[g]);

    assert_write_only_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !exec && !ldac_fall |=> $stable(dac[g]) && $stable(inp[g]));
  end

  assert_bitcount_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CW'(FRAME));

  assert_drop_R3: assert property (@(posedge clk) disable iff (!rst_n)
    sync_s |=> cnt == '0);

  assert_mask_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !exec |=> $stable(mask));
endmodule

// File: tb/octal_dac_core_tb.sv
module octal_dac_core_tb;
  localparam int NCH = 8;
  localparam int DW = 14;

  logic clk = 0, rst_n = 0, sclk = 1, sync_n = 1, din = 0, ldac_n = 1;
  logic [NCH*DW-1:0] dac_out;
  int total = 0, bad = 0;

  logic [DW-1:0] m_inp [NCH];
  logic [DW-1:0] m_dac [NCH];
  logic [NCH-1:0] m_mask;

  octal_dac_core #(.NCH(NCH), .DW(DW), .SYNC_STAGES(2)) u_dut (
    .clk(clk), .rst_n(rst_n), .sclk(sclk), .sync_n(sync_n),
    .din(din), .ldac_n(ldac_n), .dac_out(dac_out));

  always #2 clk = ~clk;

  function automatic logic [NCH*DW-1:0] exp_bus();
    logic [NCH*DW-1:0] b;
    for (int i = 0; i < NCH; i++) b[i*DW +: DW] = m_dac[i];
    return b;
  endfunction

  function automatic logic [31:0] mk(input logic [3:0] c, input logic [3:0] a,
                                     input logic [DW-1:0] d, input logic [7:0] lo);
    return {4'hA, c, a, d, 6'(lo)} | {24'd0, lo};
  endfunction

  task automatic model(input logic [31:0] w);
    logic [3:0] c = w[27:24];
    logic [3:0] a = w[23:20];
    logic [DW-1:0] d = w[19 -: DW];
    logic [NCH-1:0] s, u;
    logic wr = (c == 0) || (c == 2) || (c == 3);
    for (int i = 0; i < NCH; i++) begin
      s[i] = (a == 4'hF) || (a == 4'(i));
      if (wr && s[i]) m_inp[i] = d;
      u[i] = (!ldac_n && !m_mask[i]) || (c == 3) || (s[i] && (c == 1 || c == 2))
           || (s[i] && m_mask[i] && c == 0);
    end
    for (int i = 0; i < NCH; i++) if (u[i]) m_dac[i] = m_inp[i];
    if (c == 6) m_mask = w[7:0];
  endtask

  task automatic cyc(input int n);
    repeat (n) @(posedge clk);
  endtask

  task automatic send(input logic [31:0] w, input int nbits);
    sync_n = 0;
    cyc(4);
    for (int k = 0; k < nbits; k++) begin
      sclk = 1;
      din = (k < 32) ? w[31-k] : 1'b1;
      cyc(4);
      sclk = 0;
      cyc(4);
    end
    sclk = 1;
    cyc(4);
    sync_n = 1;
    cyc(8);
    if (nbits >= 32) model(w);
  endtask

  task automatic pin_pulse();
    ldac_n = 0;
    cyc(8);
    for (int i = 0; i < NCH; i++) if (!m_mask[i]) m_dac[i] = m_inp[i];
    ldac_n = 1;
    cyc(8);
  endtask

  task automatic check(input string req);
    @(negedge clk);
    total++;
    if (dac_out !== exp_bus()) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, dac_out, exp_bus());
    end
  endtask

  initial begin
    #1000000;
    bad++;
    total++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    m_mask = '0;
    for (int i = 0; i < NCH; i++) begin
      m_inp[i] = '0;
      m_dac[i] = '0;
    end
    cyc(5);
    rst_n = 1;
    cyc(5);
    check("R1");

    send(mk(4'h0, 4'h2, 14'h1234, 8'h00), 32);
    check("R4");
    send(mk(4'h1, 4'h2, 14'h0, 8'h00), 32);
    check("R5");
    send(mk(4'h2, 4'h5, 14'h2ABC, 8'h00), 32);
    check("R6");
    send(mk(4'h0, 4'h7, 14'h0777, 8'h00), 32);
    send(mk(4'h3, 4'h0, 14'h3FFF, 8'h00), 32);
    check("R7");
    send(mk(4'h2, 4'h3, 14'h1111, 8'h00), 20);
    check("R3");
    send(mk(4'h2, 4'h9, 14'h2222, 8'h00), 32);
    check("R12 dead address");
    send(mk(4'h2, 4'hF, 14'h0F0F, 8'h00), 32);
    check("R12 broadcast");
    send(mk(4'h9, 4'h1, 14'h3333, 8'h00), 32);
    check("R12 unused command");
    send(mk(4'h2, 4'h1, 14'h0155, 8'h00), 36);
    check("R2 overlong");
    send(mk(4'h6, 4'h3, 14'h3FFF, 8'hA5), 32);
    send(mk(4'h0, 4'h0, 14'h0ABC, 8'h00), 32);
    check("R9 masked channel");
    send(mk(4'h0, 4'h1, 14'h0DEF, 8'h00), 32);
    check("R8 unmasked channel waits");
    pin_pulse();
    check("R10");
    ldac_n = 0;
    cyc(8);
    for (int i = 0; i < NCH; i++) if (!m_mask[i]) m_dac[i] = m_inp[i];
    send(mk(4'h0, 4'h4, 14'h1357, 8'h00), 32);
    check("R11");
    ldac_n = 1;
    cyc(8);

    for (int n = 0; n < 120; n++) begin
      int r = $urandom_range(0, 9);
      logic [3:0] c;
      case (r)
        0, 1: c = 4'h0;
        2: c = 4'h1;
        3: c = 4'h2;
        4: c = 4'h3;
        5: c = 4'h6;
        default: c = 4'($urandom_range(0, 15));
      endcase
      if ($urandom_range(0, 7) == 0) pin_pulse();
      send(mk(c, 4'($urandom_range(0, 15)), 14'($urandom), 8'($urandom)),
           ($urandom_range(0, 9) == 0) ? 17 : 32);
      check("R2 random");
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule